// File: doc/BRIEF.md
# Nonvolatile Store Sequencer

This block sequences the slow write cycle that moves data into the nonvolatile data registers of a serial-controlled potentiometer and comparator device. A frame decoder upstream reports each decoded instruction opcode with a one-cycle `cmd_valid` strobe. It also reports, with `frame_done`, that the frame carried every byte its instruction needs. The sequencer arms only on the three opcodes that write nonvolatile storage. It waits for chip select to return high. Only then does it issue a one-cycle `commit` pulse to the data registers.

After a commit, `busy` stays high for a programmable number of system-clock cycles that models the store time. The default of 1,250,000 cycles is 10 ms at 125 MHz. While busy, further store commands are dropped, and other commands pass untouched. The hardware write-protect input is sampled at the chip-select rising edge. A low level there cancels the store. The busy flag is also presented as a status byte, which the read path returns for the status opcode.

All inputs are synchronous to `clk`. Reset is asynchronous, active low and released synchronously inside the block.

Top module: `nvs_store_seq`

## Requirements
- R1: While `rst_n` is low, `commit`, `commit_all` and `busy` are 0 and `status_byte` is 8'h00. This holds also when reset is applied in the middle of a store.
- R2: Only the opcodes 4'b1100 (write data register), 4'b1110 (single live-to-data transfer) and 4'b1000 (transfer of all live registers) arm a store. After a complete frame with any other opcode, the chip-select rise gives no commit and no busy.
- R3: A store starts only at the chip-select rising edge, never at `frame_done`. The edge is the first clock edge that samples `cs_n` high after it was sampled low. `commit` is high for exactly the one cycle after that edge.
- R4: If `frame_done` was not seen for the armed command by the chip-select rise, no store starts. The arming is discarded, so a later empty frame also gives no commit.
- R5: If `wp_n` is low at the chip-select rising edge, no store starts and `busy` stays 0.
- R6: `busy` rises together with `commit` and stays high for exactly STORE_CYCLES cycles.
- R7: A store opcode that is sampled while `busy` is 1 is ignored, including in the last busy cycle. A store opcode sampled in the first cycle after `busy` falls is accepted.
- R8: `status_byte` bit 0 equals the busy state and bits 7:1 are always 0.
- R9: `commit_all` pulses together with `commit` exactly when the committed opcode was 4'b1000.
- R10: A `frame_done` in the same cycle as the chip-select rising edge counts as a complete frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low, synchronous to clk |
| wp_n | input | 1 | Write protect; low blocks stores |
| cmd_valid | input | 1 | One-cycle strobe: cmd_op holds a decoded opcode |
| cmd_op | input | 4 | Instruction opcode (upper nibble of the instruction byte) |
| frame_done | input | 1 | One-cycle strobe: the current frame is complete |
| commit | output | 1 | One-cycle pulse that commits the data registers |
| commit_all | output | 1 | Qualifies commit as a transfer of all live registers |
| busy | output | 1 | Store cycle in progress |
| status_byte | output | 8 | Status data byte; bit 0 is the busy flag |

## Verification
Two pairs of events can fall in the same cycle.

The first pair is the end of a store window and a new store opcode. The bench issues a store opcode in the last cycle in which `busy` is high and expects it to be dropped. It then repeats the sequence one cycle later and expects a commit.

The second pair is frame completion and chip-select release. The bench drives `frame_done` and the rising `cs_n` in the same cycle and expects the store to start, as it does when the strobe comes earlier.

// File: rtl/nvs_pkg.sv
package nvs_pkg;

  localparam int OPCODE_W = 4;
  localparam int STATUS_W = 8;

  localparam logic [OPCODE_W-1:0] OP_WRITE_DR       = 4'b1100;
  localparam logic [OPCODE_W-1:0] OP_LIVE_TO_DR     = 4'b1110;
  localparam logic [OPCODE_W-1:0] OP_ALL_LIVE_TO_DR = 4'b1000;

  typedef enum logic [1:0] {
    ARM_IDLE  = 2'd0,
    ARM_WAIT  = 2'd1,
    ARM_READY = 2'd2
  } arm_state_t;

  function automatic logic op_is_store(input logic [OPCODE_W-1:0] op);
    return (op == OP_WRITE_DR) || (op == OP_LIVE_TO_DR) || (op == OP_ALL_LIVE_TO_DR);
  endfunction

  function automatic logic op_is_global(input logic [OPCODE_W-1:0] op);
    return (op == OP_ALL_LIVE_TO_DR);
  endfunction

endpackage

// File: rtl/nvs_rst_sync.sv
module nvs_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/nvs_cs_edge.sv
module nvs_cs_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  output logic cs_rise
);

  logic cs_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q <= 1'b1;
    end else begin
      cs_q <= cs_n;
    end
  end

  assign cs_rise = cs_n & ~cs_q;

endmodule

// File: rtl/nvs_arm.sv
module nvs_arm
  import nvs_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cmd_valid,
  input  logic [OPCODE_W-1:0] cmd_op,
  input  logic                frame_done,
  input  logic                cs_rise,
  input  logic                wp_n,
  input  logic                busy,
  output logic                go,
  output logic                go_all
);

  arm_state_t state_q, state_d;
  logic       glob_q, glob_d;
  logic       complete;

  // A frame counts as complete when the strobe was seen earlier or lands now.
  assign complete = (state_q == ARM_READY) || ((state_q == ARM_WAIT) && frame_done);

  always_comb begin
    state_d = state_q;
    glob_d  = glob_q;
    go      = 1'b0;
    unique case (state_q)
      ARM_IDLE: begin
        if (cmd_valid && op_is_store(cmd_op) && !busy) begin
          state_d = ARM_WAIT;
          glob_d  = op_is_global(cmd_op);
        end
      end
      ARM_WAIT: begin
        if (frame_done) begin
          state_d = ARM_READY;
        end
      end
      ARM_READY: begin
        state_d = ARM_READY;
      end
      default: begin
        state_d = ARM_IDLE;
      end
    endcase
    if (cs_rise) begin
      state_d = ARM_IDLE;
      go      = wp_n && complete;
    end
  end

  assign go_all = go & glob_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ARM_IDLE;
      glob_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      glob_q  <= glob_d;
    end
  end

endmodule

// File: rtl/nvs_busy_timer.sv
module nvs_busy_timer #(
  parameter int STORE_CYCLES = 1250000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);

  localparam int CNT_W = (STORE_CYCLES > 1) ? $clog2(STORE_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(STORE_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             busy_q, busy_d;

  always_comb begin
    cnt_d  = cnt_q;
    busy_d = busy_q;
    if (start) begin
      busy_d = 1'b1;
      cnt_d  = LOAD;
    end else if (busy_q) begin
      if (cnt_q == '0) begin
        busy_d = 1'b0;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
    end
  end

  assign busy = busy_q;

endmodule

// File: rtl/nvs_store_seq.sv
module nvs_store_seq
  import nvs_pkg::*;
#(
  parameter int STORE_CYCLES = 1250000
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cs_n,
  input  logic                wp_n,
  input  logic                cmd_valid,
  input  logic [OPCODE_W-1:0] cmd_op,
  input  logic                frame_done,
  output logic                commit,
  output logic                commit_all,
  output logic                busy,
  output logic [STATUS_W-1:0] status_byte
);

  logic rst_int_n;
  logic cs_rise;
  logic go, go_all;
  logic commit_q, commit_all_q;

  nvs_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  nvs_cs_edge u_edge (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .cs_n    (cs_n),
    .cs_rise (cs_rise)
  );

  nvs_arm u_arm (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .cmd_valid  (cmd_valid),
    .cmd_op     (cmd_op),
    .frame_done (frame_done),
    .cs_rise    (cs_rise),
    .wp_n       (wp_n),
    .busy       (busy),
    .go         (go),
    .go_all     (go_all)
  );

  nvs_busy_timer #(.STORE_CYCLES(STORE_CYCLES)) u_timer (
    .clk   (clk),
    .rst_n (rst_int_n),
    .start (go),
    .busy  (busy)
  );

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      commit_q     <= 1'b0;
      commit_all_q <= 1'b0;
    end else begin
      commit_q     <= go;
      commit_all_q <= go_all;
    end
  end

  assign commit      = commit_q;
  assign commit_all  = commit_all_q;
  assign status_byte = {{(STATUS_W-1){1'b0}}, busy};

endmodule

// File: rtl/nvs_store_seq_chk.sv
module nvs_store_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_n,
  input logic       wp_n,
  input logic       commit,
  input logic       commit_all,
  input logic       busy,
  input logic [7:0] status_byte
);

  // R3
  commit_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> !commit);

  // R3
  commit_after_cs_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> ($past(cs_n) && !$past(cs_n, 2)));

  // R5
  commit_needs_wp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> $past(wp_n));

  // R6
  busy_with_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> busy);

  // R6
  busy_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> commit);

  // R7
  no_commit_when_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !commit);

  // R9
  global_qualifies_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit_all |-> commit);

endmodule

bind nvs_store_seq nvs_store_seq_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cs_n        (cs_n),
  .wp_n        (wp_n),
  .commit      (commit),
  .commit_all  (commit_all),
  .busy        (busy),
  .status_byte (status_byte)
);

// File: tb/sim_nvs_store_seq.sv
`timescale 1ns/1ps
module sim_nvs_store_seq;

  localparam int STORE = 20;
  localparam int NVEC  = 14;

  // {op[8:5], complete[4], wp_n[3], same_cycle[2], exp_commit[1], exp_all[0]}
  localparam logic [8:0] VEC [NVEC] = '{
    {4'b1100, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0},
    {4'b1110, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0},
    {4'b1000, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1},
    {4'b1100, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},
    {4'b1000, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
    {4'b1110, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
    {4'b1001, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0},
    {4'b1010, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0},
    {4'b1101, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0},
    {4'b0001, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0},
    {4'b0101, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0},
    {4'b1100, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0},
    {4'b1000, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1},
    {4'b1110, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0}
  };

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cs_n, wp_n, cmd_valid, frame_done;
  logic [3:0] cmd_op;
  logic       commit, commit_all, busy;
  logic [7:0] status_byte;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  nvs_store_seq #(.STORE_CYCLES(STORE)) u0 (
    .clk         (clk),
    .rst_n       (rst_n),
    .cs_n        (cs_n),
    .wp_n        (wp_n),
    .cmd_valid   (cmd_valid),
    .cmd_op      (cmd_op),
    .frame_done  (frame_done),
    .commit      (commit),
    .commit_all  (commit_all),
    .busy        (busy),
    .status_byte (status_byte)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic send_cmd(input logic [3:0] op);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_op    = op;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic pulse_done();
    @(negedge clk);
    frame_done = 1'b1;
    @(negedge clk);
    frame_done = 1'b0;
  endtask

  task automatic run_frame(input logic [3:0] op, input bit cmp, input bit wp,
                           input bit same, input bit ec, input bit ea,
                           input string tag);
    int n;
    @(negedge clk);
    cs_n = 1'b0;
    send_cmd(op);
    if (cmp && !same) pulse_done();
    @(negedge clk);
    check(commit == 1'b0 && busy == 1'b0, tag, "store before cs rise",
          int'(commit) + int'(busy), 0);
    wp_n = wp;
    cs_n = 1'b1;
    if (cmp && same) frame_done = 1'b1;
    @(negedge clk);
    frame_done = 1'b0;
    wp_n = 1'b1;
    check(commit == ec, tag, "commit after cs rise", int'(commit), int'(ec));
    check(commit_all == ea, "R9", "commit_all", int'(commit_all), int'(ea));
    check(busy == ec, tag, "busy after cs rise", int'(busy), int'(ec));
    if (ec) begin
      n = 1;
      check(status_byte == 8'h01, "R8", "status while busy", int'(status_byte), 1);
      @(negedge clk);
      check(commit == 1'b0, "R3", "commit width", int'(commit), 0);
      while (busy) begin
        n++;
        @(negedge clk);
      end
      check(n == STORE, "R6", "busy length", n, STORE);
      check(status_byte == 8'h00, "R8", "status after store", int'(status_byte), 0);
    end else begin
      @(negedge clk);
      cs_n = 1'b0;
      @(negedge clk);
      cs_n = 1'b1;
      @(negedge clk);
      check(commit == 1'b0 && busy == 1'b0, tag, "empty frame after no store",
            int'(commit) + int'(busy), 0);
    end
  endtask

  // Store opcode issued k cycles after the commit cycle; busy lasts STORE cycles.
  task automatic late_cmd_try(input int k, input bit exp);
    @(negedge clk);
    cs_n = 1'b0;
    send_cmd(4'b1100);
    pulse_done();
    @(negedge clk);
    cs_n = 1'b1;
    @(negedge clk);
    check(commit == 1'b1, "R7", "setup commit", int'(commit), 1);
    cs_n = 1'b0;
    repeat (k) @(negedge clk);
    check(busy == !exp, "R7", "busy when late opcode sampled", int'(busy), int'(!exp));
    cmd_valid = 1'b1;
    cmd_op    = 4'b1100;
    @(negedge clk);
    cmd_valid = 1'b0;
    pulse_done();
    @(negedge clk);
    cs_n = 1'b1;
    @(negedge clk);
    check(commit == exp, "R7", "commit from opcode at busy edge", int'(commit), int'(exp));
    while (busy) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    cs_n = 1'b1;
    wp_n = 1'b1;
    cmd_valid = 1'b0;
    frame_done = 1'b0;
    cmd_op = 4'h0;
    repeat (3) @(negedge clk);
    check(commit == 0 && commit_all == 0 && busy == 0 && status_byte == 8'h00,
          "R1", "reset state", int'(status_byte) + int'(commit), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(busy == 0 && status_byte == 8'h00, "R1", "after reset release",
          int'(status_byte), 0);

    // Table walk: R2, R3, R4, R5, R6, R8, R9, R10
    for (int i = 0; i < NVEC; i++) begin
      string tag;
      logic [3:0] op;
      op = VEC[i][8:5];
      if (VEC[i][2]) tag = "R10";
      else if (VEC[i][1]) tag = "R3";
      else if (!(op == 4'b1100 || op == 4'b1110 || op == 4'b1000)) tag = "R2";
      else if (!VEC[i][4]) tag = "R4";
      else tag = "R5";
      run_frame(op, VEC[i][4], VEC[i][3], VEC[i][2], VEC[i][1], VEC[i][0], tag);
    end

    // R7: a whole store frame inside the busy window is dropped
    @(negedge clk);
    cs_n = 1'b0;
    send_cmd(4'b1000);
    pulse_done();
    @(negedge clk);
    cs_n = 1'b1;
    @(negedge clk);
    check(commit == 1'b1, "R7", "first store", int'(commit), 1);
    cs_n = 1'b0;
    send_cmd(4'b1110);
    pulse_done();
    @(negedge clk);
    cs_n = 1'b1;
    @(negedge clk);
    check(commit == 1'b0 && busy == 1'b1, "R7", "store while busy",
          int'(commit), 0);
    while (busy) @(negedge clk);
    @(negedge clk);
    cs_n = 1'b0;
    @(negedge clk);
    cs_n = 1'b1;
    @(negedge clk);
    check(commit == 1'b0, "R7", "dropped store stays dropped", int'(commit), 0);

    // R7: last busy cycle versus first idle cycle
    late_cmd_try(STORE - 1, 1'b0);
    late_cmd_try(STORE, 1'b1);

    // R1: reset during a store
    @(negedge clk);
    cs_n = 1'b0;
    send_cmd(4'b1100);
    pulse_done();
    @(negedge clk);
    cs_n = 1'b1;
    repeat (3) @(negedge clk);
    check(busy == 1'b1, "R1", "busy before mid reset", int'(busy), 1);
    rst_n = 1'b0;
    #1;
    check(busy == 1'b0 && status_byte == 8'h00, "R1", "reset clears busy",
          int'(busy), 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (STORE + 4) @(negedge clk);
    check(busy == 1'b0 && commit == 1'b0, "R1", "idle after reset",
          int'(busy), 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule